// File: doc/BRIEF.md
# Page Access Rights and Fault Encoder

This block sits at the end of a page-table walk. It receives the combined permission summary that the walker built across every level: the user bit, the write bit and the no-execute bit, each merged over all levels. It also receives the protection key of the leaf entry, the walk outcome and the mode controls in force for the access. From these it derives the read, write and execute rights of the page. It narrows those rights with the per-key disable bits from one of two key registers. It then decides whether the requested load, store or fetch may proceed.

The result is registered. One cycle after a request the block pulses a completion strobe together with the final rights and an allow flag. When the access is refused, or the walker reported a missing entry or a reserved-bit violation, it instead pulses a fault strobe carrying an architectural page-fault error code and the virtual address of the access. Fetching table entries, setting accessed or dirty bits and nested translation are handled elsewhere.

Top module: `pg_access_judge`

## Requirements
- R1: Walk status 1 (entry absent) produces a fault whose error code has bit 0 (present) clear and bit 3 clear, and captures the request's virtual address on the fault address output.
- R2: Walk status 2 (reserved bits set) produces a fault with error code bit 3 set and bit 0 clear; walk status 0 means the walk succeeded.
- R3: A user-mode access (user input high) to a page whose combined user bit is clear faults with error code bit 0 set and bit 5 clear, whatever the other rights.
- R4: Read right (rights bit 0) is granted unless supervisor access prevention is active and the page is a user page.
- R5: Write right (rights bit 1) is granted only with read right, and then if the combined write bit is set or the access is supervisor-mode with write-protect off.
- R6: Execute right (rights bit 2) is granted when the combined no-execute bit is clear and the access is user-mode, or when execute prevention is off, or when the page is a supervisor page.
- R7: User pages take their key bits from the user key register when user keys are enabled; supervisor pages take them from the supervisor key register when supervisor keys are enabled; otherwise no key restriction applies.
- R8: For key k, register bit 2k (access-disable) removes read and write; bit 2k+1 (write-disable) removes write only if the access is user-mode or write-protect is on.
- R9: A key restriction that refuses the access is reported ahead of the ordinary rights check, with error code bits 5 and 0 set; fetches (access type 2) are never refused by a key.
- R10: Access types are 0 load, 1 store, 2 fetch. Error code bit 1 is set for stores, bit 2 for user-mode accesses, and bit 4 for fetches only while no-execute enable or execute prevention is on.
- R11: Outputs are registered: each request yields exactly one completion pulse on the next cycle, with either the allow flag or the fault strobe; no pulse appears without a request, and reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Check request, one cycle per access |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Access made in user mode |
| req_vaddr | input | VA_W | Virtual address of the access |
| walk_stat | input | 2 | Walk outcome: 0 ok, 1 absent, 2 reserved |
| pg_user | input | 1 | Combined user bit over all levels |
| pg_write | input | 1 | Combined write bit over all levels |
| pg_nx | input | 1 | Combined no-execute bit over all levels |
| pg_key | input | KEY_W | Protection key of the leaf entry |
| md_nxe | input | 1 | No-execute enable |
| md_wp | input | 1 | Supervisor write-protect |
| md_sxp | input | 1 | Supervisor execute prevention |
| md_sap | input | 1 | Supervisor access prevention active for this access |
| md_ukey_en | input | 1 | User-page keys enabled |
| md_skey_en | input | 1 | Supervisor-page keys enabled |
| ukey_reg | input | 2*2^KEY_W | User key register |
| skey_reg | input | 2*2^KEY_W | Supervisor key register |
| chk_done | output | 1 | Completion pulse |
| chk_ok | output | 1 | Access allowed |
| chk_rights | output | 3 | Rights after key narrowing: bit 0 read, 1 write, 2 execute (0 on walk fault) |
| flt_valid | output | 1 | Fault pulse |
| flt_code | output | 6 | Page-fault error code |
| flt_addr | output | VA_W | Faulting virtual address |

## Verification
The properties assume that the access type is never 3 and that the walk status is never 3, since neither encoding has a meaning here; every bench scenario drives only load, store or fetch with one of the three defined walk outcomes. They also assume requests are single-cycle pulses with inputs held steady while the request is high, which the bench guarantees by driving each request for exactly one cycle away from the clock edge and dropping it before the next.

// File: rtl/pgaj_pkg.sv
package pgaj_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        WALK_OK     = 2'd0,
        WALK_ABSENT = 2'd1,
        WALK_RSVD   = 2'd2
    } walk_e;

    // bit n allows access type n
    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } rights_t;

    localparam int EC_W   = 6;
    localparam int EC_P   = 0;
    localparam int EC_WR  = 1;
    localparam int EC_US  = 2;
    localparam int EC_RSV = 3;
    localparam int EC_ID  = 4;
    localparam int EC_PK  = 5;

    typedef enum logic [1:0] {
        VERD_OK,
        VERD_WALK,
        VERD_PROT,
        VERD_KEY
    } verdict_e;

    function automatic logic allows(rights_t r, acc_e a);
        case (a)
            ACC_LOAD:  return r.rd;
            ACC_STORE: return r.wr;
            ACC_FETCH: return r.ex;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pgaj_rights.sv
module pgaj_rights
    import pgaj_pkg::*;
(
    input  logic    user,
    input  logic    pg_user,
    input  logic    pg_write,
    input  logic    pg_nx,
    input  logic    md_wp,
    input  logic    md_sxp,
    input  logic    md_sap,
    output rights_t base
);
    always_comb begin
        base.rd = !(md_sap && pg_user);
        base.wr = base.rd && (pg_write || (!user && !md_wp));
        base.ex = !pg_nx && (user || !(md_sxp && pg_user));
    end
endmodule

// File: rtl/pgaj_keygate.sv
module pgaj_keygate
    import pgaj_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int KREG_W = 2 * (1 << KEY_W)
) (
    input  logic              user,
    input  logic              pg_user,
    input  logic [KEY_W-1:0]  pg_key,
    input  logic              md_wp,
    input  logic              md_ukey_en,
    input  logic              md_skey_en,
    input  logic [KREG_W-1:0] ukey_reg,
    input  logic [KREG_W-1:0] skey_reg,
    output rights_t           kmask
);
    logic [KREG_W-1:0] sel;
    logic [1:0]        kbits;

    always_comb begin
        if (pg_user)
            sel = md_ukey_en ? ukey_reg : '0;
        else
            sel = md_skey_en ? skey_reg : '0;
        kbits = sel[2*pg_key +: 2];
        kmask = '{ex: 1'b1, wr: 1'b1, rd: 1'b1};
        if (kbits[0]) begin
            kmask.rd = 1'b0;
            kmask.wr = 1'b0;
        end else if (kbits[1] && (user || md_wp)) begin
            kmask.wr = 1'b0;
        end
    end
endmodule

// File: rtl/pgaj_errcode.sv
module pgaj_errcode
    import pgaj_pkg::*;
(
    input  verdict_e        verdict,
    input  walk_e           walk,
    input  acc_e            acc,
    input  logic            user,
    input  logic            md_nxe,
    input  logic            md_sxp,
    output logic [EC_W-1:0] code
);
    always_comb begin
        code = '0;
        code[EC_P]   = (verdict == VERD_PROT) || (verdict == VERD_KEY);
        code[EC_PK]  = (verdict == VERD_KEY);
        code[EC_RSV] = (verdict == VERD_WALK) && (walk == WALK_RSVD);
        code[EC_US]  = user;
        code[EC_WR]  = (acc == ACC_STORE);
        code[EC_ID]  = (acc == ACC_FETCH) && (md_nxe || md_sxp);
    end
endmodule

// File: rtl/pg_access_judge.sv
module pg_access_judge
    import pgaj_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int KEY_W = 4,
    localparam int KREG_W = 2 * (1 << KEY_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        walk_stat,
    input  logic              pg_user,
    input  logic              pg_write,
    input  logic              pg_nx,
    input  logic [KEY_W-1:0]  pg_key,
    input  logic              md_nxe,
    input  logic              md_wp,
    input  logic              md_sxp,
    input  logic              md_sap,
    input  logic              md_ukey_en,
    input  logic              md_skey_en,
    input  logic [KREG_W-1:0] ukey_reg,
    input  logic [KREG_W-1:0] skey_reg,
    output logic              chk_done,
    output logic              chk_ok,
    output logic [2:0]        chk_rights,
    output logic              flt_valid,
    output logic [5:0]        flt_code,
    output logic [VA_W-1:0]   flt_addr
);
    acc_e            acc;
    walk_e           walk;
    rights_t         base, kmask, fin;
    verdict_e        verdict;
    logic [EC_W-1:0] code;

    assign acc  = acc_e'(req_acc);
    assign walk = walk_e'(walk_stat);

    pgaj_rights u_rights (
        .user(req_user), .pg_user(pg_user), .pg_write(pg_write), .pg_nx(pg_nx),
        .md_wp(md_wp), .md_sxp(md_sxp), .md_sap(md_sap), .base(base)
    );

    pgaj_keygate #(.KEY_W(KEY_W)) u_keygate (
        .user(req_user), .pg_user(pg_user), .pg_key(pg_key), .md_wp(md_wp),
        .md_ukey_en(md_ukey_en), .md_skey_en(md_skey_en),
        .ukey_reg(ukey_reg), .skey_reg(skey_reg), .kmask(kmask)
    );

    assign fin = base & kmask;

    always_comb begin
        if (walk != WALK_OK)
            verdict = VERD_WALK;
        else if (req_user && !pg_user)
            verdict = VERD_PROT;
        else if (!allows(kmask, acc))
            verdict = VERD_KEY;
        else if (!allows(fin, acc))
            verdict = VERD_PROT;
        else
            verdict = VERD_OK;
    end

    pgaj_errcode u_errcode (
        .verdict(verdict), .walk(walk), .acc(acc), .user(req_user),
        .md_nxe(md_nxe), .md_sxp(md_sxp), .code(code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done   <= 1'b0;
            chk_ok     <= 1'b0;
            chk_rights <= '0;
            flt_valid  <= 1'b0;
            flt_code   <= '0;
            flt_addr   <= '0;
        end else begin
            chk_done  <= req_valid;
            chk_ok    <= req_valid && (verdict == VERD_OK);
            flt_valid <= req_valid && (verdict != VERD_OK);
            if (req_valid) begin
                chk_rights <= (walk == WALK_OK) ? fin : 3'b000;
                flt_code   <= (verdict == VERD_OK) ? '0 : code;
                flt_addr   <= req_vaddr;
            end
        end
    end
endmodule

// File: rtl/pgaj_checker.sv
module pgaj_checker #(
    parameter int VA_W = 48
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [1:0]      req_acc,
    input logic            req_user,
    input logic [1:0]      walk_stat,
    input logic            pg_user,
    input logic            chk_done,
    input logic            chk_ok,
    input logic [2:0]      chk_rights,
    input logic            flt_valid,
    input logic [5:0]      flt_code,
    input logic [VA_W-1:0] flt_addr
);
    a_r11_done_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> chk_done);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !chk_done && !flt_valid && !chk_ok);
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (chk_ok != flt_valid));
    a_r1_absent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && walk_stat == 2'd1) |=> flt_valid && !flt_code[0] && !flt_code[3]);
    a_r2_reserved: assert property (@(posedge clk) disable iff (rst)
        (req_valid && walk_stat == 2'd2) |=> flt_valid && flt_code[3] && !flt_code[0]);
    a_r3_user_on_sup: assert property (@(posedge clk) disable iff (rst)
        (req_valid && walk_stat == 2'd0 && req_user && !pg_user)
        |=> flt_valid && flt_code[0] && !flt_code[5]);
    a_r5_write_needs_read: assert property (@(posedge clk) disable iff (rst)
        chk_rights[1] |-> chk_rights[0]);
    a_r9_key_not_fetch: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && flt_code[5]) |-> flt_code[0] && !flt_code[4]);
    a_r10_store_bit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_acc == 2'd1) |=> flt_code[1] || !flt_valid);
    a_r10_user_bit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user) |=> flt_code[2] || !flt_valid);
endmodule

bind pg_access_judge pgaj_checker #(.VA_W(VA_W)) u_pgaj_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_acc(req_acc),
    .req_user(req_user), .walk_stat(walk_stat), .pg_user(pg_user),
    .chk_done(chk_done), .chk_ok(chk_ok), .chk_rights(chk_rights),
    .flt_valid(flt_valid), .flt_code(flt_code), .flt_addr(flt_addr)
);

// File: tb/test_pg_access_judge.sv
module test_pg_access_judge;
    localparam int VA_W = 48;
    localparam int KEY_W = 4;
    localparam int KREG_W = 2 * (1 << KEY_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              req_valid = 0;
    logic [1:0]        req_acc = 0;
    logic              req_user = 0;
    logic [VA_W-1:0]   req_vaddr = 0;
    logic [1:0]        walk_stat = 0;
    logic              pg_user = 0, pg_write = 0, pg_nx = 0;
    logic [KEY_W-1:0]  pg_key = 0;
    logic              md_nxe = 1, md_wp = 0, md_sxp = 0, md_sap = 0;
    logic              md_ukey_en = 0, md_skey_en = 0;
    logic [KREG_W-1:0] ukey_reg = 0, skey_reg = 0;
    logic              chk_done, chk_ok, flt_valid;
    logic [2:0]        chk_rights;
    logic [5:0]        flt_code;
    logic [VA_W-1:0]   flt_addr;

    int checks = 0;
    int errors = 0;

    pg_access_judge #(.VA_W(VA_W), .KEY_W(KEY_W)) i_pg_access_judge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_acc(req_acc),
        .req_user(req_user), .req_vaddr(req_vaddr), .walk_stat(walk_stat),
        .pg_user(pg_user), .pg_write(pg_write), .pg_nx(pg_nx), .pg_key(pg_key),
        .md_nxe(md_nxe), .md_wp(md_wp), .md_sxp(md_sxp), .md_sap(md_sap),
        .md_ukey_en(md_ukey_en), .md_skey_en(md_skey_en),
        .ukey_reg(ukey_reg), .skey_reg(skey_reg),
        .chk_done(chk_done), .chk_ok(chk_ok), .chk_rights(chk_rights),
        .flt_valid(flt_valid), .flt_code(flt_code), .flt_addr(flt_addr)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // one request; outputs are checked on the following falling edge
    task automatic access(input string tag, input logic [1:0] acc, input logic usr,
                          input logic [1:0] ws, input logic pu, input logic pw,
                          input logic px, input logic [VA_W-1:0] va,
                          input logic exp_ok, input logic [2:0] exp_rights,
                          input logic [5:0] exp_code);
        @(negedge clk);
        req_acc = acc; req_user = usr; walk_stat = ws;
        pg_user = pu; pg_write = pw; pg_nx = px; req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " done"}, {63'd0, chk_done}, 64'd1);
        check({tag, " ok"}, {63'd0, chk_ok}, {63'd0, exp_ok});
        check({tag, " fault"}, {63'd0, flt_valid}, {63'd0, !exp_ok});
        check({tag, " rights"}, {61'd0, chk_rights}, {61'd0, exp_rights});
        if (!exp_ok) begin
            check({tag, " code"}, {58'd0, flt_code}, {58'd0, exp_code});
            check({tag, " addr"}, {16'd0, flt_addr}, {16'd0, va});
        end
        @(negedge clk);
        check({tag, " pulse ends"}, {62'd0, chk_done, flt_valid}, 64'd0);
    endtask

    task automatic t_reset();
        check("R11 reset done", {63'd0, chk_done}, 64'd0);
        check("R11 reset fault", {63'd0, flt_valid}, 64'd0);
        check("R11 reset code", {58'd0, flt_code}, 64'd0);
    endtask

    task automatic t_walk();
        // absent, user store: W|U
        access("R1 absent", 2'd1, 1'b1, 2'd1, 1, 1, 0, 48'h7FFF_1234_5678, 0, 3'b000, 6'h06);
        // reserved, supervisor fetch, nxe on: RSV|ID
        access("R2 reserved", 2'd2, 1'b0, 2'd2, 1, 1, 0, 48'h0000_0040_1000, 0, 3'b000, 6'h18);
        md_nxe = 0;
        access("R10 fetch no id", 2'd2, 1'b0, 2'd1, 0, 1, 0, 48'h0000_0000_2000, 0, 3'b000, 6'h00);
        md_nxe = 1;
    endtask

    task automatic t_user_sup();
        access("R3 user on sup", 2'd0, 1'b1, 2'd0, 0, 1, 0, 48'h1000, 0, 3'b111, 6'h05);
    endtask

    task automatic t_read();
        md_sap = 1;
        access("R4 sap user page", 2'd0, 1'b0, 2'd0, 1, 1, 0, 48'h3000, 0, 3'b100, 6'h01);
        access("R4 sap sup page", 2'd0, 1'b0, 2'd0, 0, 1, 0, 48'h3000, 1, 3'b111, 6'h00);
        md_sap = 0;
    endtask

    task automatic t_write();
        access("R5 sup wp off", 2'd1, 1'b0, 2'd0, 0, 0, 0, 48'h4000, 1, 3'b111, 6'h00);
        md_wp = 1;
        access("R5 sup wp on", 2'd1, 1'b0, 2'd0, 0, 0, 0, 48'h4008, 0, 3'b101, 6'h03);
        md_wp = 0;
        access("R5 user ro", 2'd1, 1'b1, 2'd0, 1, 0, 0, 48'h4010, 0, 3'b101, 6'h07);
    endtask

    task automatic t_exec();
        md_sxp = 1;
        access("R6 sxp user page", 2'd2, 1'b0, 2'd0, 1, 1, 0, 48'h5000, 0, 3'b011, 6'h11);
        access("R6 sxp user mode", 2'd2, 1'b1, 2'd0, 1, 1, 0, 48'h5000, 1, 3'b111, 6'h00);
        md_sxp = 0;
        access("R6 nx set", 2'd2, 1'b1, 2'd0, 1, 1, 1, 48'h5040, 0, 3'b011, 6'h15);
    endtask

    task automatic t_keys();
        pg_key = 4'd3;
        ukey_reg = '0; ukey_reg[6] = 1'b1;          // AD for key 3
        access("R7 keys off", 2'd0, 1'b1, 2'd0, 1, 1, 0, 48'h6000, 1, 3'b111, 6'h00);
        md_ukey_en = 1;
        access("R8 AD load", 2'd0, 1'b1, 2'd0, 1, 1, 0, 48'h6000, 0, 3'b100, 6'h25);
        access("R9 AD fetch ok", 2'd2, 1'b1, 2'd0, 1, 1, 0, 48'h6000, 1, 3'b100, 6'h00);
        access("R7 sup page ignores ukey", 2'd0, 1'b0, 2'd0, 0, 1, 0, 48'h6100, 1, 3'b111, 6'h00);
        md_skey_en = 1;
        skey_reg = '0; skey_reg[7] = 1'b1;          // WD for key 3
        access("R8 WD sup wp off", 2'd1, 1'b0, 2'd0, 0, 1, 0, 48'h6200, 1, 3'b111, 6'h00);
        md_wp = 1;
        access("R8 WD sup wp on", 2'd1, 1'b0, 2'd0, 0, 1, 0, 48'h6200, 0, 3'b101, 6'h23);
        md_wp = 0;
        ukey_reg = '0; ukey_reg[7] = 1'b1;          // WD for key 3
        access("R9 key before prot", 2'd1, 1'b1, 2'd0, 1, 0, 0, 48'h6300, 0, 3'b101, 6'h27);
        pg_key = 4'd4;
        access("R7 other key free", 2'd1, 1'b1, 2'd0, 1, 1, 0, 48'h6400, 1, 3'b111, 6'h00);
        md_ukey_en = 0; md_skey_en = 0; pg_key = 0;
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R11 idle", {62'd0, chk_done, flt_valid}, 64'd0);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_walk();
                t_user_sup();
                t_read();
                t_write();
                t_exec();
                t_keys();
                t_idle();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule